// File: doc/BRIEF.md
# Edge/Level Interrupt Delivery Engine

This block decides when each input of an interrupt router must be sent to the processors. Every input has a routing entry with a vector, a polarity, a trigger type and a mask. The engine turns each raw input level into an effective level and keeps a pending bit for every input. For edge-triggered inputs it requests a delivery once per rising pending bit. For level-triggered inputs it delivers while a per-entry in-service flag (remote-IRR) is clear. It sets that flag when a destination accepts the message and clears it when an end-of-interrupt (EOI) for the entry's vector arrives.

Only one delivery request is outstanding at a time. Inputs that wait together are served lowest index first. The downstream side answers each request with one `ack_i` pulse, together with `accepted_i`, which says whether any destination took the message. The engine also keeps a 256-bit map with one bit for each vector that is used in any entry.

Top module: `irq_delivery_engine`

## Requirements
- R1: While `rst_ni` is low and directly after it rises, `req_valid_o`, `pending_o`, `remote_irr_o`, `coalesced_o` and `vector_map_o` are all zero.
- R2: The effective level of input i is `line_i[i] ^ polarity_i[i]`, so polarity 1 means active-low. `pending_o[i]` shows the effective level one clock later, and an inactive effective level clears it.
- R3: An unmasked edge input (`trig_level_i[i]`=0) gets exactly one request for each 0-to-1 change of its pending bit. Holding the level gives no further request, and edge inputs never set remote-IRR.
- R4: If the pending bit of an edge input rises again while its earlier rise has not yet been issued, the input still gets a single request and `coalesced_o[i]` pulses for one cycle.
- R5: An unmasked level input (`trig_level_i[i]`=1) with its pending bit set is requested while `remote_irr_o[i]` is 0. An ack with `accepted_i`=1 sets `remote_irr_o[i]`, and no further request follows.
- R6: A rise of a level input's pending bit while its remote-IRR is set makes no request and pulses `coalesced_o[i]`.
- R7: A masked entry (`mask_i[i]`=1) is never requested. An edge that rises while the entry is masked is dropped and is not delivered when the entry is later unmasked.
- R8: An EOI with `eoi_level_i`=1 clears remote-IRR on every level entry whose vector equals `eoi_vector_i`. Such an entry that is unmasked and still pending is requested again.
- R9: An EOI with `eoi_level_i`=0, or with a vector that no entry uses, leaves every remote-IRR bit unchanged.
- R10: An ack with `accepted_i`=0 leaves remote-IRR clear, and an input that is still pending at level is requested again.
- R11: Inputs that wait together are issued lowest index first, one at a time. `req_index_o`, `req_vector_o` and `req_level_o` hold steady until `ack_i`. The request rises two clocks after the input changes.
- R12: `vector_map_o[v]` is 1 exactly when some entry has vector v, where entry i's vector is `vector_i[i*8 +: 8]`. The map follows a table change one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | NUM_IN | Raw input levels |
| polarity_i | input | NUM_IN | 1 = input is active-low |
| trig_level_i | input | NUM_IN | 1 = level trigger, 0 = edge trigger |
| mask_i | input | NUM_IN | 1 = entry masked |
| vector_i | input | NUM_IN*VEC_W | Entry vectors, entry i at bits [i*VEC_W +: VEC_W] |
| eoi_valid_i | input | 1 | EOI strobe, one cycle |
| eoi_level_i | input | 1 | EOI type, 1 = level |
| eoi_vector_i | input | VEC_W | Vector the EOI refers to |
| ack_i | input | 1 | Result of the outstanding request |
| accepted_i | input | 1 | With ack_i: at least one destination took it |
| req_valid_o | output | 1 | Delivery request outstanding |
| req_index_o | output | IDX_W | Input being delivered |
| req_vector_o | output | VEC_W | Vector of the delivery |
| req_level_o | output | 1 | Delivery is level-triggered |
| pending_o | output | NUM_IN | Pending bits |
| remote_irr_o | output | NUM_IN | Remote-IRR bits |
| coalesced_o | output | NUM_IN | One-cycle pulse when an assertion was folded |
| vector_map_o | output | 2**VEC_W | Vectors present in the table |

## Verification
Edge inputs are driven by a held level, by a rise while masked, and by a double rise under a blocked request. Together these separate "one request per pending rise" from both level-style redelivery and lost edges. Level inputs run through accepted and refused acks and through EOIs of either type with matching and foreign vectors. This shows that remote-IRR is the only gate and that only a level EOI clears it. Two entries share one vector so that the EOI has to reach all of them. Two inputs that rise together, held without an ack, show the issue order and that the request fields stay stable.

// File: rtl/irq_deliv_pkg.sv
package irq_deliv_pkg;
  localparam int unsigned VEC_W = 8;
  localparam int unsigned MAP_W = 1 << VEC_W;
endpackage

// File: rtl/irq_lane.sv
module irq_lane #(
  parameter int unsigned VEC_W = irq_deliv_pkg::VEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             pol_i,
  input  logic             lvl_i,
  input  logic             mask_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             eoi_valid_i,
  input  logic             eoi_lvl_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  input  logic             grant_i,
  input  logic             done_i,
  input  logic             accepted_i,
  output logic             want_o,
  output logic             pending_o,
  output logic             rirr_o,
  output logic             coalesce_o
);
  logic eff, rise, eoi_hit;
  logic pend_q, need_q, rirr_q, coal_q;

  assign eff     = line_i ^ pol_i;
  assign rise    = eff & ~pend_q;
  assign eoi_hit = eoi_valid_i & eoi_lvl_i & (eoi_vec_i == vec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      need_q <= 1'b0;
      rirr_q <= 1'b0;
      coal_q <= 1'b0;
    end else begin
      pend_q <= eff;
      // edge request: a new rise wins over the grant that consumes an old one
      if (mask_i || lvl_i)   need_q <= 1'b0;
      else if (rise)         need_q <= 1'b1;
      else if (grant_i)      need_q <= 1'b0;
      if (!lvl_i)                    rirr_q <= 1'b0;
      else if (done_i && accepted_i) rirr_q <= 1'b1;
      else if (eoi_hit)              rirr_q <= 1'b0;
      coal_q <= rise & ~mask_i & (lvl_i ? rirr_q : (need_q & ~grant_i));
    end
  end

  assign want_o     = ~mask_i & (lvl_i ? (pend_q & ~rirr_q) : need_q);
  assign pending_o  = pend_q;
  assign rirr_o     = rirr_q;
  assign coalesce_o = coal_q;

  AST_GRANT_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> !mask_i); // R7
  AST_LEVEL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && lvl_i) |-> !rirr_q); // R5
  AST_RIRR_SET_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rirr_q) |-> $past(done_i && accepted_i)); // R5
  AST_RIRR_CLEAR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rirr_q) |-> $past((eoi_valid_i && eoi_lvl_i && eoi_vec_i == vec_i) || !lvl_i)); // R8
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NUM_IN = 8,
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] want_i,
  input  logic              en_i,
  output logic [NUM_IN-1:0] grant_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (want_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign grant_o = (en_i && (|want_i)) ? (NUM_IN'(1) << idx_o) : '0;

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R11
  AST_LOWEST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> ((want_i & (grant_o - NUM_IN'(1))) == '0)); // R11
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned VEC_W  = irq_deliv_pkg::VEC_W,
  localparam int unsigned MAP_W = 1 << VEC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_IN*VEC_W-1:0] vec_i,
  output logic [MAP_W-1:0]        map_o
);
  logic [MAP_W-1:0] map_d, map_q;

  always_comb begin
    map_d = '0;
    for (int i = 0; i < NUM_IN; i++) map_d[vec_i[i*VEC_W +: VEC_W]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_q <= '0;
    else         map_q <= map_d;
  end

  assign map_o = map_q;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_chk
    AST_MAP_HAS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> map_q[$past(vec_i[g*VEC_W +: VEC_W])]); // R12
  end
endmodule

// File: rtl/irq_delivery_engine.sv
module irq_delivery_engine #(
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned VEC_W  = irq_deliv_pkg::VEC_W,
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int unsigned MAP_W = 1 << VEC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_IN-1:0]       line_i,
  input  logic [NUM_IN-1:0]       polarity_i,
  input  logic [NUM_IN-1:0]       trig_level_i,
  input  logic [NUM_IN-1:0]       mask_i,
  input  logic [NUM_IN*VEC_W-1:0] vector_i,
  input  logic                    eoi_valid_i,
  input  logic                    eoi_level_i,
  input  logic [VEC_W-1:0]        eoi_vector_i,
  input  logic                    ack_i,
  input  logic                    accepted_i,
  output logic                    req_valid_o,
  output logic [IDX_W-1:0]        req_index_o,
  output logic [VEC_W-1:0]        req_vector_o,
  output logic                    req_level_o,
  output logic [NUM_IN-1:0]       pending_o,
  output logic [NUM_IN-1:0]       remote_irr_o,
  output logic [NUM_IN-1:0]       coalesced_o,
  output logic [MAP_W-1:0]        vector_map_o
);
  logic [NUM_IN-1:0] want, grant, done;
  logic [IDX_W-1:0]  pick_idx;
  logic              busy_q, lvl_q;
  logic [IDX_W-1:0]  idx_q;
  logic [VEC_W-1:0]  vec_q;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    assign done[g] = busy_q & ack_i & (idx_q == IDX_W'(g));
    irq_lane #(.VEC_W(VEC_W)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .line_i      (line_i[g]),
      .pol_i       (polarity_i[g]),
      .lvl_i       (trig_level_i[g]),
      .mask_i      (mask_i[g]),
      .vec_i       (vector_i[g*VEC_W +: VEC_W]),
      .eoi_valid_i (eoi_valid_i),
      .eoi_lvl_i   (eoi_level_i),
      .eoi_vec_i   (eoi_vector_i),
      .grant_i     (grant[g]),
      .done_i      (done[g]),
      .accepted_i  (accepted_i),
      .want_o      (want[g]),
      .pending_o   (pending_o[g]),
      .rirr_o      (remote_irr_o[g]),
      .coalesce_o  (coalesced_o[g])
    );
  end

  irq_pick #(.NUM_IN(NUM_IN)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .want_i  (want),
    .en_i    (~busy_q),
    .grant_o (grant),
    .idx_o   (pick_idx)
  );

  irq_vec_map #(.NUM_IN(NUM_IN), .VEC_W(VEC_W)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vec_i  (vector_i),
    .map_o  (vector_map_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      vec_q  <= '0;
      lvl_q  <= 1'b0;
    end else if (!busy_q) begin
      if (|grant) begin
        busy_q <= 1'b1;
        idx_q  <= pick_idx;
        vec_q  <= vector_i[pick_idx*VEC_W +: VEC_W];
        lvl_q  <= trig_level_i[pick_idx];
      end
    end else if (ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign req_valid_o  = busy_q;
  assign req_index_o  = idx_q;
  assign req_vector_o = vec_q;
  assign req_level_o  = lvl_q;

  AST_HOLD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !ack_i) |=> (req_valid_o && $stable(req_index_o)
                                 && $stable(req_vector_o) && $stable(req_level_o))); // R11
  AST_DROP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && ack_i) |=> !req_valid_o); // R11
  AST_EDGE_NO_RIRR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((remote_irr_o & ~trig_level_i) == '0) |=> ((remote_irr_o & ~$past(trig_level_i)) == '0)); // R3
endmodule

// File: tb/irq_delivery_engine_test.sv
module irq_delivery_engine_test;
  localparam int N = 8;
  localparam int VW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] line_i = '0, polarity_i = '0, trig_level_i = '0, mask_i = '1;
  logic [VW-1:0] vec [N];
  logic [N*VW-1:0] vector_i;
  logic eoi_valid_i = 0, eoi_level_i = 0, ack_i = 0, accepted_i = 0;
  logic [VW-1:0] eoi_vector_i = '0;
  logic req_valid_o, req_level_o;
  logic [2:0] req_index_o;
  logic [VW-1:0] req_vector_o;
  logic [N-1:0] pending_o, remote_irr_o, coalesced_o;
  logic [255:0] vector_map_o;

  int compared = 0;
  int mismatched = 0;

  always #2 clk_i = ~clk_i;

  always_comb begin
    for (int i = 0; i < N; i++) vector_i[i*VW +: VW] = vec[i];
  end

  irq_delivery_engine #(.NUM_IN(N), .VEC_W(VW)) uut (.*);

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic give_ack(logic acc);
    ack_i = 1'b1; accepted_i = acc;
    step(1);
    ack_i = 1'b0; accepted_i = 1'b0;
  endtask

  task automatic eoi(logic lvl, logic [VW-1:0] v);
    eoi_valid_i = 1'b1; eoi_level_i = lvl; eoi_vector_i = v;
    step(1);
    eoi_valid_i = 1'b0;
  endtask

  task automatic chk_req(string tag, int idx, logic lvl);
    chk({tag, " valid"}, 256'(req_valid_o), 256'(1));
    chk({tag, " index"}, 256'(req_index_o), 256'(idx));
    chk({tag, " vector"}, 256'(req_vector_o), 256'(vec[idx]));
    chk({tag, " level"}, 256'(req_level_o), 256'(lvl));
  endtask

  function automatic logic [255:0] exp_map();
    logic [255:0] m = '0;
    for (int i = 0; i < N; i++) m[vec[i]] = 1'b1;
    return m;
  endfunction

  task automatic t_reset();
    chk("R1 req", 256'(req_valid_o), 0);
    chk("R1 pending", 256'(pending_o), 0);
    chk("R1 rirr", 256'(remote_irr_o), 0);
    chk("R1 coalesced", 256'(coalesced_o), 0);
    chk("R1 map", vector_map_o, 0);
  endtask

  task automatic t_map();
    step(1);
    chk("R12 initial map", vector_map_o, exp_map());
    vec[3] = 8'h40;
    step(1);
    chk("R12 dup vector map", vector_map_o, exp_map());
  endtask

  task automatic t_polarity();
    polarity_i[1] = 1'b1;
    step(1);
    chk("R2 active-low pending", 256'(pending_o[1]), 1);
    line_i[1] = 1'b1;
    step(1);
    chk("R2 inactive clears", 256'(pending_o[1]), 0);
    line_i[1] = 1'b0; polarity_i[1] = 1'b0;
    step(1);
  endtask

  task automatic t_edge_basic();
    mask_i[0] = 1'b0;
    line_i[0] = 1'b1;
    step(1);
    chk("R3 no req yet", 256'(req_valid_o), 0);
    step(1);
    chk_req("R3 edge req", 0, 1'b0);
    give_ack(1'b1);
    chk("R3 req drops", 256'(req_valid_o), 0);
    step(5);
    chk("R3 held level no resend", 256'(req_valid_o), 0);
    chk("R3 edge no rirr", 256'(remote_irr_o[0]), 0);
    line_i[0] = 1'b0;
    step(1);
  endtask

  task automatic t_mask();
    line_i[4] = 1'b1;
    step(3);
    chk("R7 masked no req", 256'(req_valid_o), 0);
    chk("R7 masked still pending", 256'(pending_o[4]), 1);
    mask_i[4] = 1'b0;
    step(3);
    chk("R7 dropped edge after unmask", 256'(req_valid_o), 0);
    line_i[4] = 1'b0; mask_i[4] = 1'b1;
    step(1);
  endtask

  task automatic t_level();
    trig_level_i[5] = 1'b1; mask_i[5] = 1'b0;
    line_i[5] = 1'b1;
    step(2);
    chk_req("R5 level req", 5, 1'b1);
    give_ack(1'b1);
    chk("R5 rirr set", 256'(remote_irr_o[5]), 1);
    step(3);
    chk("R5 gated by rirr", 256'(req_valid_o), 0);
    line_i[5] = 1'b0;
    step(1);
    line_i[5] = 1'b1;
    step(1);
    chk("R6 coalesced pulse", 256'(coalesced_o[5]), 1);
    chk("R6 no req", 256'(req_valid_o), 0);
    step(1);
    chk("R6 pulse one cycle", 256'(coalesced_o[5]), 0);
  endtask

  task automatic t_eoi_ignored();
    eoi(1'b0, 8'h45);
    chk("R9 edge EOI keeps rirr", 256'(remote_irr_o[5]), 1);
    eoi(1'b1, 8'h99);
    chk("R9 foreign vector keeps rirr", 256'(remote_irr_o[5]), 1);
    step(2);
    chk("R9 no req", 256'(req_valid_o), 0);
  endtask

  task automatic t_eoi_broadcast();
    vec[6] = 8'h45; trig_level_i[6] = 1'b1; mask_i[6] = 1'b0;
    line_i[6] = 1'b1;
    step(2);
    chk_req("R8 second level req", 6, 1'b1);
    give_ack(1'b1);
    line_i[6] = 1'b0;
    step(1);
    chk("R8 both rirr set", 256'(remote_irr_o[6:5]), 256'(2'b11));
    eoi(1'b1, 8'h45);
    chk("R8 both rirr cleared", 256'(remote_irr_o[6:5]), 0);
    step(1);
    chk_req("R8 redeliver pending", 5, 1'b1);
    give_ack(1'b1);
    chk("R8 rirr after redeliver", 256'(remote_irr_o[5]), 1);
  endtask

  task automatic t_refused();
    line_i[5] = 1'b0;
    step(1);
    eoi(1'b1, 8'h45);
    step(2);
    chk("R8 no redeliver when idle", 256'(req_valid_o), 0);
    trig_level_i[7] = 1'b1; mask_i[7] = 1'b0;
    line_i[7] = 1'b1;
    step(2);
    chk_req("R10 level req", 7, 1'b1);
    give_ack(1'b0);
    chk("R10 rirr stays clear", 256'(remote_irr_o[7]), 0);
    step(1);
    chk_req("R10 resend", 7, 1'b1);
    give_ack(1'b1);
    chk("R10 rirr after accept", 256'(remote_irr_o[7]), 1);
    line_i[7] = 1'b0; mask_i[7] = 1'b1;
    step(1);
  endtask

  task automatic t_priority();
    mask_i[3:2] = 2'b00;
    line_i[3:2] = 2'b11;
    step(2);
    chk_req("R11 lowest first", 2, 1'b0);
    step(2);
    chk_req("R11 held until ack", 2, 1'b0);
    give_ack(1'b1);
    chk("R11 gap after ack", 256'(req_valid_o), 0);
    step(1);
    chk_req("R11 next index", 3, 1'b0);
    give_ack(1'b1);
    line_i[3:2] = 2'b00;
    step(1);
  endtask

  task automatic t_edge_coalesce();
    mask_i[1] = 1'b0;
    line_i[0] = 1'b1;
    step(2);
    chk_req("R4 blocker req", 0, 1'b0);
    line_i[1] = 1'b1;
    step(1);
    line_i[1] = 1'b0;
    step(1);
    line_i[1] = 1'b1;
    step(1);
    chk("R4 coalesced pulse", 256'(coalesced_o[1]), 1);
    give_ack(1'b1);
    step(1);
    chk_req("R4 single delivery", 1, 1'b0);
    give_ack(1'b1);
    step(3);
    chk("R4 no second delivery", 256'(req_valid_o), 0);
    line_i[1:0] = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) vec[i] = 8'h40 + 8'(i);
    step(3);
    rst_ni = 1'b1;
    t_reset();
    t_map();
    t_polarity();
    t_edge_basic();
    t_mask();
    t_level();
    t_eoi_ignored();
    t_eoi_broadcast();
    t_refused();
    t_priority();
    t_edge_coalesce();
    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule